// File: doc/BRIEF.md
# Delayed Exponential Synaptic Conductance Step Unit

This unit advances the conductance of one synapse by one forward-Euler time step of 0.125 ms. It is shared over many synapses: a sequencer streams each synapse's stored state in (its conductance, its pending-release history and its type), along with the presynaptic spike bit for the current step and the synapse weight. The unit returns the updated state one cycle later, to be written back to storage for the next step.

Between releases the conductance decays exponentially. Each step removes a fixed fraction of the conductance, computed with a single right shift. The shift depends on the synapse type: 3 for excitatory synapses (1 ms time constant) and 5 for inhibitory ones (4 ms). A presynaptic spike does not act at once. It enters a per-synapse history register that the caller stores with the conductance. Four steps later the spike leaves the oldest position of that register, and on that step the synapse weight is added to the conductance after the decay. The unit also returns a selector for the reversal potential of the synapse type, for use by the neuron that sums the synaptic currents.

Top module: `syn_cond_step`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 until an input is accepted.
- R2: For an excitatory synapse (`in_type`=0) whose oldest history bit `in_dly[3]` is 0, the returned conductance is `in_g - (in_g >> 3)`. The conductance is unsigned, with 12 fractional bits.
- R3: For an inhibitory synapse (`in_type`=1) whose `in_dly[3]` is 0, the returned conductance is `in_g - (in_g >> 5)`.
- R4: The returned history is `{in_dly[2:0], in_spike}`: the new spike enters bit 0 and every older bit moves up one position.
- R5: When `in_dly[3]` is 1, the weight `in_weight` is added after the decay. The spike arriving on `in_spike` in the same step has no effect on the returned conductance.
- R6: When the decayed value plus the weight exceeds 16'hFFFF, the returned conductance is 16'hFFFF.
- R7: `out_rev_sel` returns the type of the accepted synapse: 0 selects the excitatory reversal potential and 1 the inhibitory one.
- R8: An input is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` equals `!out_valid || out_ready`. The result appears with `out_valid`=1 after that edge, and `out_valid` falls after a transfer with no new input.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and no input is accepted.
- R10: When the returned state is fed back each step with `in_spike`=0 after a single spike, the conductance stays unchanged (0 here) on the four result steps that start with the spike step. On the fifth step it becomes the weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input state and step data are valid |
| in_ready | output | 1 | Unit can accept an input this cycle |
| in_g | input | 16 | Stored conductance, 12 fractional bits |
| in_dly | input | 4 | Stored spike history; bit 3 is the oldest |
| in_spike | input | 1 | Presynaptic spike in this step |
| in_weight | input | 12 | Weight added on release |
| in_type | input | 1 | Synapse type: 0 excitatory, 1 inhibitory |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_g | output | 16 | Updated conductance |
| out_dly | output | 4 | Updated spike history |
| out_rev_sel | output | 1 | Reversal-potential selector for the synapse type |

## Verification
The bench builds the unit with its default parameters: a 16-bit conductance, a 12-bit weight, a four-step history and decay shifts of 3 and 5. With these values, inputs near 16'hFFFF reach the saturation ceiling, and small conductances reach the region where the shift truncates to zero and no decay happens. The four-step history is short enough that a fed-back sequence covers the whole propagation delay of one spike. Both synapse types can reach the release step with and without saturation.

// File: rtl/syn_pkg.sv
package syn_pkg;

    localparam int unsigned COND_W_DEF  = 16;
    localparam int unsigned WGT_W_DEF   = 12;
    localparam int unsigned HIST_N_DEF  = 4;
    localparam int unsigned EXC_SH_DEF  = 3;
    localparam int unsigned INH_SH_DEF  = 5;

    typedef enum logic {
        REV_EXC = 1'b0,
        REV_INH = 1'b1
    } rev_sel_e;

endpackage

// File: rtl/syn_decay.sv
module syn_decay #(
    parameter int unsigned COND_W = 16,
    parameter int unsigned EXC_SH = 3,
    parameter int unsigned INH_SH = 5
) (
    input  logic [COND_W-1:0] g_cur,
    input  logic              inhib,
    output logic [COND_W-1:0] g_decayed
);
    logic [COND_W-1:0] loss;

    generate
        if (EXC_SH == INH_SH) begin : g_one_shift
            always_comb loss = g_cur >> EXC_SH;
        end else begin : g_two_shift
            always_comb loss = inhib ? (g_cur >> INH_SH) : (g_cur >> EXC_SH);
        end
    endgenerate

    // The loss is never larger than g_cur, so this subtraction cannot wrap.
    always_comb g_decayed = g_cur - loss;

endmodule

// File: rtl/syn_delay_line.sv
module syn_delay_line #(
    parameter int unsigned HIST_N = 4
) (
    input  logic [HIST_N-1:0] hist_cur,
    input  logic              spike,
    output logic [HIST_N-1:0] hist_next,
    output logic              release_now
);
    generate
        if (HIST_N == 1) begin : g_single
            always_comb hist_next = spike;
        end else begin : g_multi
            always_comb hist_next = {hist_cur[HIST_N-2:0], spike};
        end
    endgenerate

    always_comb release_now = hist_cur[HIST_N-1];

endmodule

// File: rtl/syn_release_add.sv
module syn_release_add #(
    parameter int unsigned COND_W = 16,
    parameter int unsigned WGT_W  = 12
) (
    input  logic [COND_W-1:0] g_decayed,
    input  logic [WGT_W-1:0]  weight,
    input  logic              release_now,
    output logic [COND_W-1:0] g_next
);
    localparam logic [COND_W-1:0] G_MAX = '1;

    logic [COND_W:0] sum;

    always_comb begin
        sum = {1'b0, g_decayed};
        if (release_now) begin
            sum = sum + {{(COND_W + 1 - WGT_W){1'b0}}, weight};
        end
        g_next = sum[COND_W] ? G_MAX : sum[COND_W-1:0];
    end

endmodule

// File: rtl/syn_cond_step.sv
module syn_cond_step #(
    parameter int unsigned COND_W = syn_pkg::COND_W_DEF,
    parameter int unsigned WGT_W  = syn_pkg::WGT_W_DEF,
    parameter int unsigned HIST_N = syn_pkg::HIST_N_DEF,
    parameter int unsigned EXC_SH = syn_pkg::EXC_SH_DEF,
    parameter int unsigned INH_SH = syn_pkg::INH_SH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COND_W-1:0] in_g,
    input  logic [HIST_N-1:0] in_dly,
    input  logic              in_spike,
    input  logic [WGT_W-1:0]  in_weight,
    input  logic              in_type,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [COND_W-1:0] out_g,
    output logic [HIST_N-1:0] out_dly,
    output logic              out_rev_sel
);
    import syn_pkg::*;

    localparam int unsigned OLDEST = HIST_N - 1;

    typedef struct packed {
        logic              valid;
        logic [COND_W-1:0] g;
        logic [HIST_N-1:0] hist;
        rev_sel_e          rev;
    } step_state_t;

    step_state_t st_d, st_q;

    logic              accept;
    logic [COND_W-1:0] g_decayed;
    logic [COND_W-1:0] g_next;
    logic [HIST_N-1:0] hist_next;
    logic              release_now;

    syn_decay #(
        .COND_W (COND_W),
        .EXC_SH (EXC_SH),
        .INH_SH (INH_SH)
    ) decay_i (
        .g_cur     (in_g),
        .inhib     (in_type),
        .g_decayed (g_decayed)
    );

    syn_delay_line #(
        .HIST_N (HIST_N)
    ) delay_i (
        .hist_cur    (in_dly),
        .spike       (in_spike),
        .hist_next   (hist_next),
        .release_now (release_now)
    );

    syn_release_add #(
        .COND_W (COND_W),
        .WGT_W  (WGT_W)
    ) add_i (
        .g_decayed   (g_decayed),
        .weight      (in_weight),
        .release_now (release_now),
        .g_next      (g_next)
    );

    always_comb begin
        in_ready = !st_q.valid || out_ready;
        accept   = in_valid && in_ready;
        st_d     = st_q;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.g     = g_next;
            st_d.hist  = hist_next;
            st_d.rev   = in_type ? REV_INH : REV_EXC;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_g       = st_q.g;
    assign out_dly     = st_q.hist;
    assign out_rev_sel = st_q.rev;

    AST_NO_VALID_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

    AST_DECAY_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_dly[OLDEST]) |=> (out_g <= $past(in_g))); // R2

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_dly[0] == $past(in_spike))); // R4

    AST_RELEASE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dly[OLDEST]) |=> (out_g >= COND_W'($past(in_weight)))); // R5

    AST_REV_FOLLOWS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_rev_sel == $past(in_type))); // R7

    AST_FIRE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_g) && $stable(out_dly)
                                       && $stable(out_rev_sel))); // R9

endmodule

// File: tb/syn_cond_step_tb.sv
module syn_cond_step_tb_top;

    typedef struct packed {
        logic        inh;
        logic        spk;
        logic [3:0]  dly;
        logic [15:0] g;
        logic [11:0] q;
        logic [15:0] eg;
        logic [3:0]  ed;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 4'h0, 16'h1000, 12'h000, 16'h0E00, 4'h0},  // R2 exc decay
        '{1'b1, 1'b0, 4'h0, 16'h1000, 12'h000, 16'h0F80, 4'h0},  // R3 inh decay
        '{1'b0, 1'b0, 4'h8, 16'h0800, 12'h100, 16'h0800, 4'h0},  // R5 release
        '{1'b0, 1'b0, 4'h8, 16'hFFFF, 12'hFFF, 16'hEFFF, 4'h0},  // R5 large, no sat
        '{1'b1, 1'b0, 4'h8, 16'hFFFF, 12'hFFF, 16'hFFFF, 4'h0},  // R6 saturation
        '{1'b0, 1'b1, 4'h5, 16'h0007, 12'h3AB, 16'h0007, 4'hB},  // R2 truncation, R4
        '{1'b1, 1'b0, 4'h7, 16'h0020, 12'h555, 16'h001F, 4'hE},  // R3, R4
        '{1'b0, 1'b1, 4'h8, 16'h0000, 12'h123, 16'h0123, 4'h1},  // R5 new spike ignored
        '{1'b1, 1'b1, 4'h9, 16'h0400, 12'h010, 16'h03F0, 4'h3}   // R5 inh release
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_g = '0;
    logic [3:0]  in_dly = '0;
    logic        in_spike = 1'b0;
    logic [11:0] in_weight = '0;
    logic        in_type = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_g;
    logic [3:0]  out_dly;
    logic        out_rev_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    syn_cond_step dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_g        (in_g),
        .in_dly      (in_dly),
        .in_spike    (in_spike),
        .in_weight   (in_weight),
        .in_type     (in_type),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_g       (out_g),
        .out_dly     (out_dly),
        .out_rev_sel (out_rev_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic s, input logic [3:0] d,
                        input logic [15:0] g, input logic [11:0] q);
        @(negedge clk);
        in_type = t; in_spike = s; in_dly = d; in_g = g; in_weight = q;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] fb_g;
        logic [3:0]  fb_d;
        logic [15:0] held_g;

        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        check("R8 ready when empty", 32'(in_ready), 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].inh, VEC[i].spk, VEC[i].dly, VEC[i].g, VEC[i].q);
            check("R8 valid after accept", 32'(out_valid), 32'd1);
            check("R2/R3/R5/R6 conductance", 32'(out_g), 32'(VEC[i].eg));
            check("R4 history", 32'(out_dly), 32'(VEC[i].ed));
            check("R7 reversal selector", 32'(out_rev_sel), 32'(VEC[i].inh));
        end

        @(negedge clk);
        check("R8 valid falls after transfer", 32'(out_valid), 32'd0);

        // R9: stall with a result held, offer new inputs
        out_ready = 1'b0;
        step(1'b0, 1'b0, 4'h0, 16'h2000, 12'h000);
        held_g = out_g;
        check("R9 held value", 32'(held_g), 32'h1C00);
        check("R8 ready low on stall", 32'(in_ready), 32'd0);
        in_valid = 1'b1; in_g = 16'h0100; in_dly = 4'hF; in_spike = 1'b1; in_type = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 g stable", 32'(out_g), 32'(held_g));
        check("R9 dly stable", 32'(out_dly), 32'h0);
        check("R9 rev stable", 32'(out_rev_sel), 32'd0);
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check("R8 valid drops after drain", 32'(out_valid), 32'd0);

        // R10: one spike fed back through the history
        fb_g = 16'h0000;
        fb_d = 4'h0;
        for (int k = 0; k < 5; k++) begin
            step(1'b0, (k == 0), fb_d, fb_g, 12'h2A0);
            fb_g = out_g;
            fb_d = out_dly;
            check("R10 delayed release", 32'(fb_g), (k == 4) ? 32'h2A0 : 32'h0);
        end

        finish_run();
    end

endmodule